// File: doc/BRIEF.md
# Signed Register-Pair Divider

This block performs signed division of a 32-bit dividend by a 16-bit divisor, one quotient bit per clock. The caller presents the dividend, which would normally come from an even/odd register pair, together with the divisor and a one-cycle start pulse. The block strips the signs, runs a restoring shift-and-subtract loop on the magnitudes and then applies the signs again. The quotient is bound for the even register and the remainder for the odd register. A write-enable pulse tells the register file when both words are valid.

The quotient is truncated toward zero, and its sign is the exclusive-or of the operand signs. The remainder carries the dividend's sign. Four condition flags are produced with every completion. Two conditions end without a write: a zero divisor, which completes at once, and a quotient whose magnitude needs more than 15 bits. Each has its own fixed flag code.

Top module: `sdiv_pair`

## Requirements
- R1: While reset is held and just after it, busy, done and wr_en are 0, and quotient, remainder and flags are all 0.
- R2: A start seen while idle with a nonzero divisor raises busy in the next cycle. done is high for exactly one cycle, the cycle after the 33rd rising edge that follows the start edge, and busy is low in that cycle.
- R3: The written quotient is the magnitude of dividend/divisor truncated toward zero. It is negated when exactly one operand is negative.
- R4: The written remainder has magnitude |dividend| mod |divisor| and is negated when the dividend is negative, so -5/2 gives -2 rem -1 and -5/-2 gives 2 rem -1.
- R5: A start while idle with a zero divisor gives done in the cycle after the start edge with flags 4'b0111, no wr_en and no change to quotient or remainder. busy stays low.
- R6: If the quotient magnitude is 32768 or more (this includes a result of exactly -32768), completion gives flags 4'b0010 with no wr_en, and quotient and remainder keep their old values.
- R7: The flags port is {N,Z,V,C} in bits 3..0. On a written result, N is bit 15 of the quotient, Z is set when the quotient is 0, and V and C are 0.
- R8: wr_en is high only in a done cycle, and it is high in exactly those done cycles that write a result.
- R9: A start while busy is ignored, even one carrying a zero divisor. It does not change the result, the flags or the completion cycle of the divide in progress.
- R10: quotient and remainder change only in a cycle where wr_en is high, and flags change only in a done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide (taken only when idle) |
| dividend | input | 32 | Signed dividend, high word from the even register |
| divisor | input | 16 | Signed divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Quotient and remainder are to be written |
| quotient | output | 16 | Signed quotient for the even register |
| remainder | output | 16 | Signed remainder for the odd register |
| flags | output | 4 | {N,Z,V,C} |

## Verification
The assertions assume that start comes from synchronous logic and is never X. They also assume that the operands are stable at the edge on which start is taken, because the block samples them only then. Operands that change later are allowed. The stimulus drives every input on the falling edge and holds start for exactly one cycle. It pulses start during a busy window only on purpose, to exercise R9. The random operands use both signs and a wide range of magnitudes, so that written results, overflows and zero divisors all occur.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  localparam cc_t CC_DIV0 = '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
  localparam cc_t CC_OVF  = '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
endpackage

// File: rtl/sdiv_mag.sv
module sdiv_mag #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] mag,
  output logic         neg
);
  assign neg = val[W-1];
  assign mag = neg ? (~val + W'(1)) : val;
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DVD_W-1:0] dvd_mag,
  input  logic [DVS_W-1:0] dvs_mag,
  output logic             run,
  output logic             fin,
  output logic [DVD_W-1:0] quo_mag,
  output logic [DVS_W-1:0] rem_mag
);
  localparam int CW = $clog2(DVD_W);

  logic [CW-1:0]    cnt;
  logic [DVS_W-1:0] dvs_r;
  logic [DVS_W:0]   partial;
  logic [DVS_W+1:0] diff;
  logic             take;
  logic [DVS_W-1:0] next_rem;

  // one restoring step: shift in the next dividend bit, try to subtract
  assign partial  = {rem_mag, quo_mag[DVD_W-1]};
  assign diff     = {1'b0, partial} - {2'b00, dvs_r};
  assign take     = ~diff[DVS_W+1];
  assign next_rem = take ? diff[DVS_W-1:0] : partial[DVS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      fin     <= 1'b0;
      cnt     <= '0;
      dvs_r   <= '0;
      quo_mag <= '0;
      rem_mag <= '0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        run     <= 1'b1;
        cnt     <= '0;
        dvs_r   <= dvs_mag;
        quo_mag <= dvd_mag;
        rem_mag <= '0;
      end else if (run) begin
        quo_mag <= {quo_mag[DVD_W-2:0], take};
        rem_mag <= next_rem;
        cnt     <= cnt + CW'(1);
        if (cnt == CW'(DVD_W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix
  import sdiv_pkg::*;
#(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic [DVD_W-1:0] quo_mag,
  input  logic [DVS_W-1:0] rem_mag,
  input  logic             q_neg,
  input  logic             r_neg,
  output logic [DVS_W-1:0] quo,
  output logic [DVS_W-1:0] rem,
  output logic             ovf,
  output cc_t              cc
);
  logic [DVS_W-1:0] q_low;

  // magnitude must fit in DVS_W-1 bits
  assign ovf   = |quo_mag[DVD_W-1:DVS_W-1];
  assign q_low = quo_mag[DVS_W-1:0];
  assign quo   = q_neg ? (~q_low + DVS_W'(1)) : q_low;
  assign rem   = r_neg ? (~rem_mag + DVS_W'(1)) : rem_mag;

  always_comb begin
    cc.n = quo[DVS_W-1];
    cc.z = (quo == '0);
    cc.v = 1'b0;
    cc.c = 1'b0;
  end
endmodule

// File: rtl/sdiv_pair.sv
module sdiv_pair
  import sdiv_pkg::*;
#(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [DVS_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder,
  output logic [3:0]       flags
);
  logic [DVD_W-1:0] dvd_mag;
  logic [DVS_W-1:0] dvs_mag;
  logic             dvd_neg, dvs_neg;
  logic             run, fin;
  logic [DVD_W-1:0] quo_mag;
  logic [DVS_W-1:0] rem_mag;
  logic             q_neg_r, r_neg_r;
  logic [DVS_W-1:0] quo_fix, rem_fix;
  logic             ovf;
  cc_t              cc_fix;
  cc_t              cc_r;
  logic             accept, load, zero_hit;

  assign busy     = run | fin;
  assign accept   = start & ~busy;
  assign load     = accept & (divisor != '0);
  assign zero_hit = accept & (divisor == '0);

  sdiv_mag #(.W(DVD_W)) u_mag_dvd (.val(dividend), .mag(dvd_mag), .neg(dvd_neg));
  sdiv_mag #(.W(DVS_W)) u_mag_dvs (.val(divisor),  .mag(dvs_mag), .neg(dvs_neg));

  sdiv_core #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_core (
    .clk(clk), .rst(rst), .load(load),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .run(run), .fin(fin),
    .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  sdiv_fix #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_fix (
    .quo_mag(quo_mag), .rem_mag(rem_mag),
    .q_neg(q_neg_r), .r_neg(r_neg_r),
    .quo(quo_fix), .rem(rem_fix), .ovf(ovf), .cc(cc_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_neg_r   <= 1'b0;
      r_neg_r   <= 1'b0;
      done      <= 1'b0;
      wr_en     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      cc_r      <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (load) begin
        q_neg_r <= dvd_neg ^ dvs_neg;
        r_neg_r <= dvd_neg;
      end
      if (zero_hit) begin
        done <= 1'b1;
        cc_r <= CC_DIV0;
      end else if (fin) begin
        done <= 1'b1;
        if (ovf) begin
          cc_r <= CC_OVF;
        end else begin
          wr_en     <= 1'b1;
          quotient  <= quo_fix;
          remainder <= rem_fix;
          cc_r      <= cc_fix;
        end
      end
    end
  end

  assign flags = cc_r;
endmodule

// File: rtl/sdiv_pair_chk.sv
module sdiv_pair_chk #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [DVS_W-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic             wr_en,
  input logic [DVS_W-1:0] quotient,
  input logic [DVS_W-1:0] remainder,
  input logic [3:0]       flags
);
  localparam int BW = $clog2(DVD_W + 2) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else              bcnt <= bcnt + BW'(1);
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt <= BW'(DVD_W)));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor != '0) |=> busy);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  div0_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && !wr_en && flags == 4'b0111 && !busy));

  // R8
  wr_done_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  // R7
  wr_flags_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (flags[1:0] == 2'b00 && flags[3] == quotient[DVS_W-1]
               && flags[2] == (quotient == '0)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (done && flags[1]) |-> !wr_en);

  // R10
  hold_q_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wr_en || ($stable(quotient) && $stable(remainder))));

  // R10
  hold_f_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (done || $stable(flags)));
endmodule

bind sdiv_pair sdiv_pair_chk #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .wr_en(wr_en),
  .quotient(quotient), .remainder(remainder), .flags(flags)
);

// File: tb/sdiv_pair_test.sv
module sdiv_pair_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, wr_en;
  logic [15:0] quotient, remainder;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] last_q = '0;
  logic [15:0] last_r = '0;

  always #2 clk = ~clk;

  sdiv_pair uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .wr_en(wr_en),
    .quotient(quotient), .remainder(remainder), .flags(flags)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected result from the requirements (R3, R4, R6, R7)
  function automatic void model(input logic [31:0] a, input logic [15:0] b,
                                output logic [15:0] q, output logic [15:0] r,
                                output logic [3:0] f, output logic w);
    longint sa, sb, ma, mb, qm, rm, qs, rs;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ma = (sa < 0) ? -sa : sa;
    mb = (sb < 0) ? -sb : sb;
    qm = ma / mb;
    rm = ma % mb;
    if (qm >= 32768) begin
      w = 1'b0;
      q = last_q;
      r = last_r;
      f = 4'b0010;
    end else begin
      qs = ((sa < 0) != (sb < 0)) ? -qm : qm;
      rs = (sa < 0) ? -rm : rm;
      w = 1'b1;
      q = qs[15:0];
      r = rs[15:0];
      f = {q[15], (q == 16'h0), 2'b00};
    end
  endfunction

  task automatic run_div(input logic [31:0] a, input logic [15:0] b, input bit poke);
    logic [15:0] eq, er;
    logic [3:0]  ef;
    logic        ew;
    int          lat;
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (b == 16'h0) begin
      chk("R5", "done", {31'b0, done}, 32'd1);
      chk("R5", "busy", {31'b0, busy}, 32'd0);
      chk("R5", "flags", {28'b0, flags}, 32'h7);
      chk("R8", "wr_en", {31'b0, wr_en}, 32'd0);
      chk("R5", "hold", {quotient, remainder}, {last_q, last_r});
    end else begin
      model(a, b, eq, er, ef, ew);
      chk("R2", "busy", {31'b0, busy}, 32'd1);
      lat = 0;
      for (int i = 1; i <= 60; i++) begin
        @(negedge clk);
        if (poke && i == 5) begin
          dividend = 32'h0000_0001;
          divisor  = 16'h0;
          start    = 1'b1;
        end else begin
          start = 1'b0;
        end
        if (done) begin
          lat = i;
          break;
        end
      end
      chk(poke ? "R9" : "R2", "latency", lat, 32'd33);
      chk("R2", "busy_at_done", {31'b0, busy}, 32'd0);
      chk(poke ? "R9" : "R3", "quotient", {16'b0, quotient}, {16'b0, eq});
      chk(poke ? "R9" : "R4", "remainder", {16'b0, remainder}, {16'b0, er});
      chk(ew ? "R7" : "R6", "flags", {28'b0, flags}, {28'b0, ef});
      chk("R8", "wr_en", {31'b0, wr_en}, {31'b0, ew});
      last_q = eq;
      last_r = er;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done_width", {31'b0, done}, 32'd0);
    chk("R10", "hold", {quotient, remainder}, {last_q, last_r});
  endtask

  initial begin
    logic [31:0] a;
    logic [15:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outs", {wr_en, quotient, remainder, flags}, 37'd0);

    run_div(32'd100, 16'd7, 0);
    run_div(-32'sd5, 16'd2, 0);
    run_div(-32'sd5, -16'sd2, 0);
    run_div(32'd5, -16'sd2, 0);
    run_div(32'd0, 16'd5, 0);
    run_div(32'd7, 16'd0, 0);
    run_div(32'h0000_7FFF, 16'd1, 0);
    run_div(-32'sd32767, 16'd1, 0);
    run_div(32'h0000_8000, 16'd1, 0);
    run_div(-32'sd32768, 16'd1, 0);
    run_div(32'h8000_0000, 16'hFFFF, 0);
    run_div(32'h8000_0000, 16'h8000, 0);
    run_div(32'd1, 16'h8000, 0);
    run_div(-32'sd3, 16'd7, 0);
    run_div(32'd1000, 16'd3, 1);

    for (int k = 0; k < 80; k++) begin
      a = $urandom >> ($urandom % 20);
      b = 16'($urandom >> ($urandom % 16));
      if ($urandom % 2) a = -a;
      if ($urandom % 2) b = -b;
      if ($urandom % 16 == 0) b = 16'h0;
      run_div(a, b, (k % 10) == 3);
    end

    summary();
    $finish;
  end
endmodule